// File: doc/BRIEF.md
# DMA Interrupt Status Controller

This block holds the register set that software uses to steer a descriptor-based Ethernet DMA and to service its interrupts. A word-addressed 32-bit register port gives access to a status word, an interrupt enable mask, a control word, a bus mode word, and a base pointer and a current descriptor pointer for each of the receive and transmit rings. The register port writes in one cycle and reads combinationally.

The transmit and receive engines report events as one-cycle set pulses, one line per status bit. Each pulse latches its status bit. It also latches a group summary bit: the normal summary for completion-type events and the abnormal summary for error-type events. Software clears status bits by writing ones to them. A single level interrupt output is high while any latched status bit is also enabled. The run bits for the two engines and the receive flush-disable bit come straight from the control word. Writing a ring base also rewinds that ring's current descriptor pointer to the same value.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 except the version word, and irq_o and all engine control outputs are low.
- R2: A write to the status word (word address 2) clears each status bit that is 1 in the written data and leaves every other status bit unchanged.
- R3: A pulse on evt_set[i] sets status bit i one cycle later. Bits 0, 2, 6 and 14 are normal events and also set bit 16. Bits 1, 3, 4, 5, 7, 8, 9, 10 and 13 are abnormal events and also set bit 15. Pulses on bits 11 and 12 have no effect.
- R4: When a set pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: irq_o is high exactly when status AND enable (word address 3) is nonzero. It reflects a write or an event from the cycle after that clock edge.
- R6: A write to the receive ring base (address 4) or the transmit ring base (address 5) loads the value into both that base and that ring's current pointer (address 6 for receive, 7 for transmit). The other ring is left unchanged.
- R7: A write to a current pointer changes only that pointer. The base keeps its value.
- R8: Bus mode (address 0) stores bits 31..1, and bit 0 always reads 0.
- R9: Address 8 always reads 0x1012, and writes to it have no effect.
- R10: Control word (address 1): rx_run_o follows bit 1, tx_run_o follows bit 13, and rx_noflush_o follows bit 24.
- R11: Reads of addresses 9 to 15 return 0.
- R12: The interrupt enable word reads back as written, with all 32 bits stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address for both read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| evt_set | input | 17 | One-cycle set pulses, one line per status bit |
| irq_o | output | 1 | Level interrupt request |
| rx_run_o | output | 1 | Receive engine enable |
| tx_run_o | output | 1 | Transmit engine enable |
| rx_noflush_o | output | 1 | Disables flushing of received frames |
| rx_ring_base_o | output | DATA_W | Receive ring base |
| rx_desc_ptr_o | output | DATA_W | Receive current descriptor pointer |
| tx_ring_base_o | output | DATA_W | Transmit ring base |
| tx_desc_ptr_o | output | DATA_W | Transmit current descriptor pointer |

## Verification
The hardest case to reach is the collision between an engine's set pulse and software's clearing write to the same status bit. It only shows up when both land on one clock edge. The stimulus raises evt_set and the status write strobe on the same falling edge, so both are sampled at the following rising edge, and then reads the bit back. The interrupt timing is probed the same way: irq_o is sampled just before and just after the edge that captures an event, which pins its one-cycle latency.

// File: rtl/dma_irq_pkg.sv
// Shared constants for the DMA interrupt status controller: register word
// addresses and the status bit groups. Assumes a 17-bit status field.
package dma_irq_pkg;
    localparam int STAT_W   = 17;
    localparam int NIS_POS  = 16;
    localparam int AIS_POS  = 15;

    localparam int ADR_BUSMODE = 0;
    localparam int ADR_CTRL    = 1;
    localparam int ADR_STATUS  = 2;
    localparam int ADR_IEN     = 3;
    localparam int ADR_RXBASE  = 4;
    localparam int ADR_TXBASE  = 5;
    localparam int ADR_RXCUR   = 6;
    localparam int ADR_TXCUR   = 7;
    localparam int ADR_VERSION = 8;

    localparam logic [STAT_W-1:0] NORMAL_MASK   = 17'h04045;
    localparam logic [STAT_W-1:0] ABNORMAL_MASK = 17'h027BA;
    localparam logic [STAT_W-1:0] VALID_MASK    = 17'h1E7FF;

    localparam int RING_RX = 0;
    localparam int RING_TX = 1;
    localparam int RING_N  = 2;
endpackage

// File: rtl/dma_stat_reg.sv
// Status word with set pulses and write-one-to-clear.
// Assumes: set pulses last one cycle; on a conflict, set beats clear.
module dma_stat_reg
    import dma_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_data,
    input  logic [STAT_W-1:0] set_pulse,
    output logic [STAT_W-1:0] stat_q
);
    logic [STAT_W-1:0] set_eff;
    logic [STAT_W-1:0] sum_vec;
    logic [STAT_W-1:0] clr_eff;

    // Keep only valid event bits and derive the group summary bits.
    always_comb begin
        set_eff          = set_pulse & VALID_MASK;
        sum_vec          = '0;
        sum_vec[NIS_POS] = |(set_eff & NORMAL_MASK);
        sum_vec[AIS_POS] = |(set_eff & ABNORMAL_MASK);
        clr_eff          = clr_we ? clr_data : '0;
    end

    // Update: clear first, then OR in new events so that set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_eff) | set_eff | sum_vec;
    end
endmodule

// File: rtl/dma_ring_ptr.sv
// Base and current descriptor pointer for one ring.
// Assumes: a base write rewinds the current pointer to the same value.
module dma_ring_ptr #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic              cur_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] base_q,
    output logic [DATA_W-1:0] cur_q
);
    // Base register: loaded only by a base write.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= wdata;
    end

    // Current pointer: loaded by a base write or a direct write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cur_q <= '0;
        else if (base_we || cur_we) cur_q <= wdata;
    end
endmodule

// File: rtl/dma_cfg_regs.sv
// Plain configuration words: bus mode, control, interrupt enable.
// Assumes: bus mode bit 0 is a self-clearing request and is never held.
module dma_cfg_regs #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busmode_we,
    input  logic              ctrl_we,
    input  logic              ien_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] busmode_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] ien_q
);
    // Bus mode: bit 0 masked off on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)          busmode_q <= '0;
        else if (busmode_we) busmode_q <= {wdata[DATA_W-1:1], 1'b0};
    end

    // Control word, stored in full.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wdata;
    end

    // Interrupt enable mask, stored in full.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_we) ien_q <= wdata;
    end
endmodule

// File: rtl/dma_irq_ctrl.sv
// Top of the DMA interrupt status controller. It decodes register writes,
// muxes reads, and drives the interrupt line and the engine control bits.
// Assumes: DATA_W >= 25, so that control bit 24 exists, and ADDR_W >= 4.
module dma_irq_ctrl
    import dma_irq_pkg::*;
#(
    parameter int              DATA_W  = 32,
    parameter int              ADDR_W  = 4,
    parameter logic [15:0]     VERSION = 16'h1012
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [STAT_W-1:0] evt_set,
    output logic              irq_o,
    output logic              rx_run_o,
    output logic              tx_run_o,
    output logic              rx_noflush_o,
    output logic [DATA_W-1:0] rx_ring_base_o,
    output logic [DATA_W-1:0] rx_desc_ptr_o,
    output logic [DATA_W-1:0] tx_ring_base_o,
    output logic [DATA_W-1:0] tx_desc_ptr_o
);
    localparam int NREG = ADR_VERSION + 1;

    logic [NREG-1:0]   wr_hit;
    logic [STAT_W-1:0] stat_q;
    logic [DATA_W-1:0] busmode_q, ctrl_q, ien_q;
    logic [DATA_W-1:0] base_q [RING_N];
    logic [DATA_W-1:0] cur_q  [RING_N];
    logic [DATA_W-1:0] stat_ext;

    // One-hot write decode, one strobe per mapped word.
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_dec
            assign wr_hit[g] = bus_wr_en && (bus_addr == ADDR_W'(g));
        end
    endgenerate

    dma_stat_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_we    (wr_hit[ADR_STATUS]),
        .clr_data  (bus_wdata[STAT_W-1:0]),
        .set_pulse (evt_set),
        .stat_q    (stat_q)
    );

    dma_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .busmode_we (wr_hit[ADR_BUSMODE]),
        .ctrl_we    (wr_hit[ADR_CTRL]),
        .ien_we     (wr_hit[ADR_IEN]),
        .wdata      (bus_wdata),
        .busmode_q  (busmode_q),
        .ctrl_q     (ctrl_q),
        .ien_q      (ien_q)
    );

    // One pointer pair per ring; base and current addresses step by one.
    generate
        for (genvar r = 0; r < RING_N; r++) begin : g_ring
            dma_ring_ptr #(.DATA_W(DATA_W)) u_ring (
                .clk     (clk),
                .rst_n   (rst_n),
                .base_we (wr_hit[ADR_RXBASE + r]),
                .cur_we  (wr_hit[ADR_RXCUR + r]),
                .wdata   (bus_wdata),
                .base_q  (base_q[r]),
                .cur_q   (cur_q[r])
            );
        end
    endgenerate

    assign stat_ext = {{(DATA_W-STAT_W){1'b0}}, stat_q};

    // Read mux; unmapped addresses return zero.
    always_comb begin
        case (int'(bus_addr))
            ADR_BUSMODE: bus_rdata = busmode_q;
            ADR_CTRL:    bus_rdata = ctrl_q;
            ADR_STATUS:  bus_rdata = stat_ext;
            ADR_IEN:     bus_rdata = ien_q;
            ADR_RXBASE:  bus_rdata = base_q[RING_RX];
            ADR_TXBASE:  bus_rdata = base_q[RING_TX];
            ADR_RXCUR:   bus_rdata = cur_q[RING_RX];
            ADR_TXCUR:   bus_rdata = cur_q[RING_TX];
            ADR_VERSION: bus_rdata = DATA_W'(VERSION);
            default:     bus_rdata = '0;
        endcase
    end

    // Interrupt level and engine controls from registered state.
    always_comb begin
        irq_o          = |(stat_ext & ien_q);
        rx_run_o       = ctrl_q[1];
        tx_run_o       = ctrl_q[13];
        rx_noflush_o   = ctrl_q[24];
        rx_ring_base_o = base_q[RING_RX];
        rx_desc_ptr_o  = cur_q[RING_RX];
        tx_ring_base_o = base_q[RING_TX];
        tx_desc_ptr_o  = cur_q[RING_TX];
    end
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
// Property checker for dma_irq_ctrl, attached through bind below.
module dma_irq_ctrl_chk
    import dma_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [STAT_W-1:0] evt_set,
    input logic [STAT_W-1:0] stat_q,
    input logic              irq_o,
    input logic [DATA_W-1:0] rx_desc_ptr_o,
    input logic [DATA_W-1:0] tx_desc_ptr_o
);
    logic st_wr;
    assign st_wr = bus_wr_en && (bus_addr == ADDR_W'(ADR_STATUS));

    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && evt_set == '0) |=> ((stat_q & $past(bus_wdata[STAT_W-1:0])) == '0));

    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=>
        ((stat_q & $past(evt_set & VALID_MASK)) == $past(evt_set & VALID_MASK)));

    assert_nis_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_set & NORMAL_MASK)) |=> stat_q[NIS_POS]);

    assert_ais_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_set & ABNORMAL_MASK)) |=> stat_q[AIS_POS]);

    assert_setwins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && evt_set[0] && bus_wdata[0]) |=> stat_q[0]);

    assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq_o);

    assert_rxbase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(ADR_RXBASE)) |=> (rx_desc_ptr_o == $past(bus_wdata)));

    assert_txbase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(ADR_TXBASE)) |=> (tx_desc_ptr_o == $past(bus_wdata)));

    assert_bm_bit0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ADR_BUSMODE)) |-> (bus_rdata[0] == 1'b0));

    assert_version_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ADR_VERSION)) |-> (bus_rdata == DATA_W'(32'h1012)));
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr_en     (bus_wr_en),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .evt_set       (evt_set),
    .stat_q        (stat_q),
    .irq_o         (irq_o),
    .rx_desc_ptr_o (rx_desc_ptr_o),
    .tx_desc_ptr_o (tx_desc_ptr_o)
);

// File: tb/test_dma_irq_ctrl.sv
// Directed bench for dma_irq_ctrl: one task per scenario, each checking itself.
module test_dma_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [16:0] evt_set = '0;
    logic        irq_o, rx_run_o, tx_run_o, rx_noflush_o;
    logic [31:0] rx_ring_base_o, rx_desc_ptr_o, tx_ring_base_o, tx_desc_ptr_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dma_irq_ctrl i_dma_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
        .irq_o(irq_o), .rx_run_o(rx_run_o), .tx_run_o(tx_run_o),
        .rx_noflush_o(rx_noflush_o), .rx_ring_base_o(rx_ring_base_o),
        .rx_desc_ptr_o(rx_desc_ptr_o), .tx_ring_base_o(tx_ring_base_o),
        .tx_desc_ptr_o(tx_desc_ptr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input int a, input logic [31:0] exp);
        bus_addr = 4'(a);
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic pulse(input logic [16:0] m);
        @(negedge clk);
        evt_set = m;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 8; a++) rd_check("R1 reg zero", a, 32'h0);
        rd_check("R1 version", 8, 32'h1012);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 ctrl outs", {29'b0, rx_run_o, tx_run_o, rx_noflush_o}, 32'h0);
    endtask

    task automatic t_events;
        pulse(17'h00001);
        rd_check("R3 normal sets NIS", 2, 32'h10001);
        pulse(17'h00080);
        rd_check("R3 abnormal sets AIS", 2, 32'h18081);
        pulse(17'h01800);
        rd_check("R3 bits 11,12 ignored", 2, 32'h18081);
        wr(2, 32'hFFFFFFFF);
        rd_check("R2 clear all", 2, 32'h0);
    endtask

    task automatic t_w1c;
        pulse(17'h00003);
        rd_check("R2 setup", 2, 32'h18003);
        wr(2, 32'h2);
        rd_check("R2 partial clear", 2, 32'h18001);
        wr(2, 32'h0);
        rd_check("R2 zero write no effect", 2, 32'h18001);
        wr(2, 32'hFFFFFFFF);
    endtask

    task automatic t_collide;
        @(negedge clk);
        evt_set = 17'h4; bus_wr_en = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h4;
        @(negedge clk);
        evt_set = '0; bus_wr_en = 1'b0;
        rd_check("R4 set beats clear", 2, 32'h10004);
        wr(2, 32'hFFFFFFFF);
    endtask

    task automatic t_irq;
        wr(3, 32'h00000040);
        rd_check("R12 enable readback", 3, 32'h40);
        pulse(17'h00001);
        check("R5 unenabled event no irq", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        evt_set = 17'h00040;
        #3;
        check("R5 irq low before edge", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        evt_set = '0;
        check("R5 irq after event", {31'b0, irq_o}, 32'h1);
        wr(2, 32'h40);
        check("R5 irq drops after clear", {31'b0, irq_o}, 32'h0);
        wr(3, 32'h00010000);
        check("R5 irq on enable write", {31'b0, irq_o}, 32'h1);
        wr(2, 32'hFFFFFFFF);
        wr(3, 32'hFFFFFFFF);
        rd_check("R12 full enable", 3, 32'hFFFFFFFF);
        wr(3, 32'h0);
    endtask

    task automatic t_rings;
        wr(4, 32'h00001000);
        rd_check("R6 rx base", 4, 32'h1000);
        rd_check("R6 rx cur rewound", 6, 32'h1000);
        check("R6 rx ptr port", rx_desc_ptr_o, 32'h1000);
        wr(6, 32'h00001040);
        rd_check("R7 rx cur write", 6, 32'h1040);
        rd_check("R7 rx base kept", 4, 32'h1000);
        wr(5, 32'h00002000);
        check("R6 tx base port", tx_ring_base_o, 32'h2000);
        check("R6 tx cur port", tx_desc_ptr_o, 32'h2000);
        check("R6 rx untouched", rx_desc_ptr_o, 32'h1040);
        wr(7, 32'h00002080);
        rd_check("R7 tx cur write", 7, 32'h2080);
        check("R7 tx base kept", tx_ring_base_o, 32'h2000);
    endtask

    task automatic t_misc;
        wr(0, 32'hFFFFFFFF);
        rd_check("R8 bus mode bit0", 0, 32'hFFFFFFFE);
        wr(8, 32'h0);
        rd_check("R9 version read-only", 8, 32'h1012);
        wr(1, 32'h01002002);
        check("R10 all on", {29'b0, rx_run_o, tx_run_o, rx_noflush_o}, 32'h7);
        wr(1, 32'h00000002);
        check("R10 rx only", {29'b0, rx_run_o, tx_run_o, rx_noflush_o}, 32'h4);
        rd_check("R11 addr 9", 9, 32'h0);
        rd_check("R11 addr 15", 15, 32'h0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset;
                t_events;
                t_w1c;
                t_collide;
                t_irq;
                t_rings;
                t_misc;
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule